// File: doc/BRIEF.md
# Edge-Triggered Phase/Frequency Comparator with Lock Flag

This block compares two divided clocks, a feedback edge stream and a reference edge stream. Both are already synchronous to a fast sampling clock. The block drives two active-low correction outputs, one asking the oscillator to speed up and one asking it to slow down. The width of each pulse tracks how many sample cycles one rising edge arrives ahead of the other. A loop filter or charge pump downstream turns these widths into a tuning voltage.

A digital integrator watches the two correction lines. It counts up in every cycle where either line is low and counts down in every cycle where both are high. Two thresholds with hysteresis turn that count into a lock flag. A power-down input parks the comparator and drops the lock flag.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst_ni` is low, `up_no` and `dn_no` are high and `lock_o` is low. The internal integrator count is at its maximum, and both inputs are treated as having been low.
- R2: A rising edge of `fp_i` means it is high in a sample and was low in the previous sample. Such an edge drives `dn_no` low from the next clock edge onward, and it stays low until the clear described in R4.
- R3: A rising edge of `fc_i` drives `up_no` low from the next clock edge onward, and it stays low until the clear described in R4.
- R4: Once both outputs are low, both return high on the following clock edge. An edge sampled in that clearing cycle is ignored. If the second stream's edge is sampled D cycles after the first, the leading output is low for D+1 cycles and the lagging output for 1 cycle.
- R5: Edges of `fp_i` and `fc_i` sampled in the same cycle drive both outputs low for exactly one cycle.
- R6: On every clock edge without power-down, the integrator count rises by one if either output was low in the cycle before and falls by one otherwise. It saturates at 0 and at 2^CNT_W-1 and never wraps.
- R7: `lock_o` rises on the clock edge after the count is below LOCK_LO. It falls on the clock edge after the count is above LOCK_HI. Between the two thresholds it holds its value. With defaults and quiet inputs, `lock_o` is first high 241 cycles after reset is released.
- R8: While `pwrdn_i` is high, each clock edge forces both outputs high, `lock_o` low and the count to its maximum. Edges seen during power-down set neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrdn_i | input | 1 | Power-down, active high, synchronous |
| fp_i | input | 1 | Divided feedback, synchronous to clk_i |
| fc_i | input | 1 | Divided reference, synchronous to clk_i |
| up_no | output | 1 | Speed-up request, active low |
| dn_no | output | 1 | Slow-down request, active low |
| lock_o | output | 1 | Lock flag, active high |

## Verification
Each correction output is registered once after the edge detector. An input edge driven before clock edge k therefore shows on the output after edge k, and the clear follows one edge after both outputs are low. The lock flag sits one register beyond the count, so it moves one edge after the count crosses a threshold. The count in turn reflects the previous cycle's outputs. The bench drives inputs on falling edges and compares all three outputs on the following falling edge against a cycle model with those same latencies. Its directed sequences count low cycles over fixed windows, and they count the cycles from reset release to the lock flag.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Internal request state, active high.
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_req_t;

    // Integrator state, sized by the widest count the project allows.
    typedef struct packed {
        logic [15:0] cnt;
        logic        lock;
    } pfd_integ_t;

    localparam int unsigned CH_FP = 0;
    localparam int unsigned CH_FC = 1;
    localparam int unsigned N_CH  = 2;

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwrdn_i,
    input  logic fp_rise_i,
    input  logic fc_rise_i,
    output logic up_o,
    output logic dn_o
);

    pfd_req_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwrdn_i) begin
            st_d = '0;
        end else if (st_q.up && st_q.dn) begin
            // both edges arrived: clear, ignoring anything seen now
            st_d = '0;
        end else begin
            st_d.up = st_q.up | fc_rise_i;
            st_d.dn = st_q.dn | fp_rise_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign up_o = st_q.up;
    assign dn_o = st_q.dn;

endmodule

// File: rtl/pfd_integ.sv
module pfd_integ #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned LOCK_LO = 16,
    parameter int unsigned LOCK_HI = 48
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pwrdn_i,
    input  logic             active_i,
    output logic             lock_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LO_V    = CNT_W'(LOCK_LO);
    localparam logic [CNT_W-1:0] HI_V    = CNT_W'(LOCK_HI);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } integ_t;

    integ_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pwrdn_i) begin
            s_d.cnt  = CNT_MAX;
            s_d.lock = 1'b0;
        end else begin
            if (active_i) begin
                if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
            end else begin
                if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
            end
            if (s_q.cnt < LO_V)      s_d.lock = 1'b1;
            else if (s_q.cnt > HI_V) s_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt  <= CNT_MAX;
            s_q.lock <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_o = s_q.lock;
    assign cnt_o  = s_q.cnt;

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned LOCK_LO = 16,
    parameter int unsigned LOCK_HI = 48
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwrdn_i,
    input  logic fp_i,
    input  logic fc_i,
    output logic up_no,
    output logic dn_no,
    output logic lock_o
);

    logic [N_CH-1:0]  ch_in;
    logic [N_CH-1:0]  ch_rise;
    logic             req_up, req_dn;
    logic [CNT_W-1:0] integ_cnt;

    assign ch_in[CH_FP] = fp_i;
    assign ch_in[CH_FC] = fc_i;

    for (genvar g = 0; g < N_CH; g++) begin : g_edge
        pfd_edge u_edge (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sig_i  (ch_in[g]),
            .rise_o (ch_rise[g])
        );
    end

    pfd_core u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pwrdn_i   (pwrdn_i),
        .fp_rise_i (ch_rise[CH_FP]),
        .fc_rise_i (ch_rise[CH_FC]),
        .up_o      (req_up),
        .dn_o      (req_dn)
    );

    pfd_integ #(
        .CNT_W   (CNT_W),
        .LOCK_LO (LOCK_LO),
        .LOCK_HI (LOCK_HI)
    ) u_integ (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pwrdn_i  (pwrdn_i),
        .active_i (req_up | req_dn),
        .lock_o   (lock_o),
        .cnt_o    (integ_cnt)
    );

    assign up_no = ~req_up;
    assign dn_no = ~req_dn;

endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned LOCK_LO = 16,
    parameter int unsigned LOCK_HI = 48
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pwrdn_i,
    input logic             fp_i,
    input logic             fc_i,
    input logic             up_no,
    input logic             dn_no,
    input logic             lock_o,
    input logic [CNT_W-1:0] integ_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LO_V    = CNT_W'(LOCK_LO);
    localparam logic [CNT_W-1:0] HI_V    = CNT_W'(LOCK_HI);

    assert_dn_needs_fp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dn_no) |-> $past(fp_i));

    assert_up_needs_fc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(up_no) |-> $past(fc_i));

    assert_clear_after_both_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!up_no && !dn_no) |=> (up_no && dn_no));

    assert_step_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(pwrdn_i) && !$stable(integ_cnt)) |->
            ((integ_cnt - $past(integ_cnt)) == CNT_W'(1) ||
             ($past(integ_cnt) - integ_cnt) == CNT_W'(1)));

    assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(integ_cnt) == CNT_MAX) |-> (integ_cnt != '0));

    assert_lock_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_o) |-> ($past(integ_cnt) < LO_V));

    assert_lock_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(lock_o) && !$past(pwrdn_i)) |-> ($past(integ_cnt) > HI_V));

    assert_pwrdn_park_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwrdn_i |=> (up_no && dn_no && !lock_o && integ_cnt == CNT_MAX));

endmodule

bind pfd_lock_top pfd_lock_chk #(
    .CNT_W   (CNT_W),
    .LOCK_LO (LOCK_LO),
    .LOCK_HI (LOCK_HI)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwrdn_i   (pwrdn_i),
    .fp_i      (fp_i),
    .fc_i      (fc_i),
    .up_no     (up_no),
    .dn_no     (dn_no),
    .lock_o    (lock_o),
    .integ_cnt (integ_cnt)
);

// File: tb/sim_pfd_lock_top.sv
module sim_pfd_lock_top;

    localparam int unsigned CNT_W   = 8;
    localparam int unsigned LOCK_LO = 16;
    localparam int unsigned LOCK_HI = 48;
    localparam int          CNT_MAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn = 1'b0;
    logic fp = 1'b0;
    logic fc = 1'b0;
    logic up_n, dn_n, lock;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10ns clk = ~clk;

    pfd_lock_top #(.CNT_W(CNT_W), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI)) u0 (
        .clk_i (clk), .rst_ni (rst_n), .pwrdn_i (pwrdn),
        .fp_i (fp), .fc_i (fc),
        .up_no (up_n), .dn_no (dn_n), .lock_o (lock)
    );

    // cycle model built from the requirements
    bit m_fpp, m_fcp, m_up, m_dn, m_lock;
    int m_cnt;

    function automatic int cnt_next(int c, bit act);
        if (act) return (c == CNT_MAX) ? c : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    function automatic bit lock_next(int c, bit l);
        if (c < int'(LOCK_LO)) return 1'b1;
        if (c > int'(LOCK_HI)) return 1'b0;
        return l;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_fpp = 0; m_fcp = 0; m_up = 0; m_dn = 0;
            m_cnt = CNT_MAX; m_lock = 0;
        end else begin
            bit fpr, fcr, act;
            fpr = fp & ~m_fpp;
            fcr = fc & ~m_fcp;
            act = m_up | m_dn;
            if (pwrdn) begin
                m_up = 0; m_dn = 0; m_cnt = CNT_MAX; m_lock = 0;
            end else begin
                if (m_up && m_dn) begin
                    m_up = 0; m_dn = 0;
                end else begin
                    m_up = m_up | fcr;
                    m_dn = m_dn | fpr;
                end
                m_lock = lock_next(m_cnt, m_lock);
                m_cnt  = cnt_next(m_cnt, act);
            end
            m_fpp = fp; m_fcp = fc;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R2 dn_no vs model", dn_n, !m_dn);
        chk("R3 up_no vs model", up_n, !m_up);
        chk("R7 lock_o vs model", lock, m_lock);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_model();
        end
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 up_no in reset", up_n, 1);
        chk("R1 dn_no in reset", dn_n, 1);
        chk("R1 lock_o in reset", lock, 0);
        rst_n = 1'b1;

        // R6/R7: quiet inputs, lock first seen after 241 cycles
        begin
            int first = -1;
            for (int i = 1; i <= 260; i++) begin
                @(negedge clk);
                cmp_model();
                if (lock && first < 0) first = i;
            end
            chk("R7 cycles to lock after reset", first, CNT_MAX - int'(LOCK_LO) + 2);
        end

        // R4: fp leads fc by 5 cycles
        begin
            int dl = 0, ul = 0;
            @(negedge clk); fp = 1'b1;
            for (int i = 1; i <= 20; i++) begin
                @(negedge clk);
                cmp_model();
                if (!dn_n) dl++;
                if (!up_n) ul++;
                if (i == 5) fc = 1'b1;
            end
            chk("R4 leading dn_no low cycles", dl, 6);
            chk("R4 lagging up_no low cycles", ul, 1);
            fp = 1'b0; fc = 1'b0;
        end

        // R3/R4: fc leads fp by 3 cycles
        begin
            int dl = 0, ul = 0;
            step(2); fc = 1'b1;
            for (int i = 1; i <= 15; i++) begin
                @(negedge clk);
                cmp_model();
                if (!dn_n) dl++;
                if (!up_n) ul++;
                if (i == 3) fp = 1'b1;
            end
            chk("R3 leading up_no low cycles", ul, 4);
            chk("R4 lagging dn_no low cycles", dl, 1);
            fp = 1'b0; fc = 1'b0;
        end

        // R5: coincident edges
        begin
            int both = 0, ul = 0;
            step(2); fp = 1'b1; fc = 1'b1;
            for (int i = 1; i <= 10; i++) begin
                @(negedge clk);
                cmp_model();
                if (!up_n && !dn_n) both++;
                if (!up_n) ul++;
            end
            chk("R5 both-low cycles", both, 1);
            chk("R5 up_no low cycles", ul, 1);
            fp = 1'b0; fc = 1'b0;
        end

        // R7 deassert: fp toggles, fc silent, dn stays low
        step(2);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            cmp_model();
            fp = ~fp;
        end
        chk("R7 lock_o dropped under steady request", lock, 0);
        chk("R2 dn_no held low without fc edge", dn_n, 0);
        fp = 1'b0;
        step(1); fc = 1'b1;
        step(3); fc = 1'b0;

        // R8: power-down parks everything and ignores edges
        step(2); fp = 1'b1;
        step(2); pwrdn = 1'b1;
        begin
            int lows = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                cmp_model();
                if (!up_n || !dn_n) lows++;
                fp = i[0]; fc = i[1];
            end
            chk("R8 outputs low during power-down", lows, 0);
            chk("R8 lock_o low during power-down", lock, 0);
        end
        pwrdn = 1'b0; fp = 1'b0; fc = 1'b0;
        step(2);

        // random phase/frequency patterns against the model (R2-R7)
        for (int blk = 0; blk < 40; blk++) begin
            int pf = 4 + ($urandom % 12);
            int pc = ((blk % 3) == 0) ? pf : 4 + ($urandom % 12);
            int off = $urandom % pc;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                cmp_model();
                fp = ((i % pf) < pf / 2);
                fc = (((i + off) % pc) < pc / 2);
                if (($urandom % 500) == 0) pwrdn = 1'b1;
                else pwrdn = 1'b0;
            end
        end
        pwrdn = 1'b0;
        step(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule